// File: doc/BRIEF.md
# CAN Base-Format Data Frame Field Parser

This block sits behind the bit sampler and destuffer of a CAN receiver. It takes one bit at a time from the destuffed stream, qualified by a valid strobe. It then walks the fields of a base-format data frame by counting bits. The fields are the 11-bit identifier, three control bits, a 4-bit length code, up to eight payload bytes and the 15-bit received CRC.

The identifier is shown on its own output once the frame is complete. A CRC-15 is computed in parallel and compared with the received value, and the result is shown on a flag. Payload bytes are stored as they complete. A 4-bit read address selects one byte at random, and that byte appears on a registered output one clock later. A busy flag covers the span from the start bit to the last CRC bit. Bit timing, stuff-bit removal, extended identifiers, remote frames and error frames are handled elsewhere.

Top module: `can_frame_parser`

## Requirements
- R1: While idle, an accepted bit of value 0 (dominant) is taken as the start bit. `busy` is high from the next clock edge onward. Accepted bits of value 1 while idle leave the block idle.
- R2: After the start bit, fields arrive in this order, most significant bit first: identifier (11 bits), three control bits, length code (4 bits), payload bytes, received CRC (15 bits). The identifier appears on `frame_id` on the clock edge that accepts the last CRC bit.
- R3: A length code of 0 to 8 gives that many payload bytes. A code of 9 to 15 is treated as 8. With a code of 0, the CRC field follows the length code directly.
- R4: Payload byte k (k = 0 for the first byte on the wire) is driven on `rd_byte` one clock after `rd_addr` equals k.
- R5: A read address of 8 or above, or at or above the number of bytes stored so far, returns 0.
- R6: A CRC-15 is computed over the start bit up to the last payload bit. It uses polynomial 0x4599, starts at zero and shifts in bits MSB first. `crc_error` is set to 1 on a mismatch with the received CRC and to 0 on a match. It updates on the clock edge that accepts the last CRC bit.
- R7: `busy` goes low on the clock edge that accepts the last CRC bit.
- R8: Cycles with `bit_valid` low do not advance the parser. `frame_id` and `crc_error` hold their values while the block is idle.
- R9: A start bit empties the byte store, so every read returns 0 until new payload bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `bit_in` for one clock |
| bit_in | input | 1 | Destuffed frame bit, 0 is dominant |
| rd_addr | input | 4 | Payload byte select |
| frame_id | output | 11 | Identifier of the last completed frame |
| rd_byte | output | 8 | Selected payload byte (registered) |
| busy | output | 1 | Frame in progress |
| crc_error | output | 1 | CRC mismatch on the last completed frame |

## Verification
The bench builds the block with its default parameters: an eight-byte store and a 4-bit read address. With these values the read port can reach addresses 8 to 15, past the end of the store. The 4-bit length field can also carry codes 9 to 15, which are larger than the store. Both the zero-return reads and the clamp to eight bytes are therefore exercised. The frames mix back-to-back valid bits with gapped ones, and include lengths 0, 1, 2, 3, 8 and 13 as well as one frame with a corrupted CRC.

// File: rtl/can_parse_pkg.sv
package can_parse_pkg;

    localparam int ID_BITS   = 11;
    localparam int CTRL_BITS = 3;
    localparam int DLC_BITS  = 4;
    localparam int CRC_BITS  = 15;
    localparam int BYTE_BITS = 8;
    localparam int DEF_BYTES = 8;
    localparam int SHIFT_W   = CRC_BITS;
    localparam int CNT_W     = $clog2(CRC_BITS);
    localparam logic [CRC_BITS-1:0] CRC_POLY = 15'h4599;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDENT,
        ST_CTRL,
        ST_LEN,
        ST_DATA,
        ST_CHECK
    } fld_state_t;

    typedef struct packed {
        logic                 valid;
        logic [ID_BITS-1:0]   ident;
        logic [CRC_BITS-1:0]  rx_crc;
    } frame_end_t;

    function automatic logic [CRC_BITS-1:0] crc_step(
        input logic [CRC_BITS-1:0] cur,
        input logic                b
    );
        logic fb;
        fb = b ^ cur[CRC_BITS-1];
        return {cur[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/can_crc15.sv
module can_crc15
    import can_parse_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic                bit_in,
    output logic [CRC_BITS-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc_step(crc, bit_in);
        end
    end

    // R6: the remainder only moves on an enabled bit
    p_crc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(crc));

endmodule

// File: rtl/can_field_seq.sv
module can_field_seq
    import can_parse_pkg::*;
#(
    parameter int MAX_BYTES = DEF_BYTES,
    localparam int LEN_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    output logic                 busy,
    output logic                 start,
    output logic                 crc_en,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [BYTE_BITS-1:0] wr_data,
    output frame_end_t           fend
);

    fld_state_t           state;
    logic [CNT_W-1:0]     cnt;
    logic [SHIFT_W-1:0]   sh;
    logic [SHIFT_W-1:0]   sh_next;
    logic [LEN_W-1:0]     nbytes;
    logic [LEN_W-1:0]     len_clamped;
    logic [IDX_W-1:0]     byte_idx;
    logic [ID_BITS-1:0]   id_hold;

    assign sh_next = {sh[SHIFT_W-2:0], bit_in};

    always_comb begin
        if (sh_next[DLC_BITS-1:0] > DLC_BITS'(MAX_BYTES)) begin
            len_clamped = LEN_W'(MAX_BYTES);
        end else begin
            len_clamped = LEN_W'(sh_next[DLC_BITS-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            nbytes   <= '0;
            byte_idx <= '0;
            id_hold  <= '0;
        end else if (bit_valid) begin
            sh <= sh_next;
            unique case (state)
                ST_IDLE: begin
                    if (!bit_in) begin
                        state <= ST_IDENT;
                        cnt   <= '0;
                    end
                end
                ST_IDENT: begin
                    if (cnt == CNT_W'(ID_BITS - 1)) begin
                        id_hold <= sh_next[ID_BITS-1:0];
                        state   <= ST_CTRL;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CTRL: begin
                    if (cnt == CNT_W'(CTRL_BITS - 1)) begin
                        state <= ST_LEN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LEN: begin
                    if (cnt == CNT_W'(DLC_BITS - 1)) begin
                        nbytes   <= len_clamped;
                        byte_idx <= '0;
                        cnt      <= '0;
                        state    <= (len_clamped == '0) ? ST_CHECK : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_W'(BYTE_BITS - 1)) begin
                        cnt      <= '0;
                        byte_idx <= byte_idx + 1'b1;
                        if (LEN_W'(byte_idx) + LEN_W'(1) == nbytes) begin
                            state <= ST_CHECK;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (cnt == CNT_W'(CRC_BITS - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign start   = bit_valid && (state == ST_IDLE) && !bit_in;
    assign crc_en  = bit_valid && (state == ST_IDENT || state == ST_CTRL ||
                                   state == ST_LEN   || state == ST_DATA);
    assign wr_en   = bit_valid && (state == ST_DATA) &&
                     (cnt == CNT_W'(BYTE_BITS - 1));
    assign wr_idx  = byte_idx;
    assign wr_data = sh_next[BYTE_BITS-1:0];

    always_comb begin
        fend.valid  = bit_valid && (state == ST_CHECK) &&
                      (cnt == CNT_W'(CRC_BITS - 1));
        fend.ident  = id_hold;
        fend.rx_crc = sh_next[CRC_BITS-1:0];
    end

    // R1: recessive bits while idle keep the parser idle
    p_idle_ones_r1: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && bit_valid && bit_in) |=> (state == ST_IDLE));

    // R8: no accepted bit, no movement
    p_gap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> ($stable(state) && $stable(cnt)));

    // R3: the byte index never passes the clamped length
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (LEN_W'(byte_idx) < nbytes));

    // R2: the bit counter stays inside the longest field
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(CRC_BITS));

endmodule

// File: rtl/can_payload_buf.sv
module can_payload_buf
    import can_parse_pkg::*;
#(
    parameter int NB   = DEF_BYTES,
    parameter int AW   = 4,
    localparam int IDX_W = $clog2(NB),
    localparam int LEN_W = $clog2(NB + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [BYTE_BITS-1:0] wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [BYTE_BITS-1:0] rd_data
);

    logic [BYTE_BITS-1:0] mem [NB];
    logic [LEN_W-1:0]     fill;

    for (genvar g = 0; g < NB; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill <= '0;
        end else if (wr_en) begin
            fill <= LEN_W'(wr_idx) + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (32'(rd_addr) < 32'(fill)) begin
            rd_data <= mem[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data <= '0;
        end
    end

    // R3: stored count never exceeds the store depth
    p_fill_max_r3: assert property (@(posedge clk) disable iff (rst)
        32'(fill) <= NB);

    // R5: addresses past the store read as zero
    p_far_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_addr) >= NB) |=> (rd_data == '0));

endmodule

// File: rtl/can_frame_parser.sv
module can_frame_parser
    import can_parse_pkg::*;
#(
    parameter int MAX_BYTES = DEF_BYTES,
    parameter int RD_AW     = 4,
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    input  logic [RD_AW-1:0]     rd_addr,
    output logic [ID_BITS-1:0]   frame_id,
    output logic [BYTE_BITS-1:0] rd_byte,
    output logic                 busy,
    output logic                 crc_error
);

    logic                 start;
    logic                 crc_en;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic [BYTE_BITS-1:0] wr_data;
    logic [CRC_BITS-1:0]  crc_calc;
    frame_end_t           fend;

    can_field_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .busy      (busy),
        .start     (start),
        .crc_en    (crc_en),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .fend      (fend)
    );

    can_crc15 u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .en     (crc_en),
        .bit_in (bit_in),
        .crc    (crc_calc)
    );

    can_payload_buf #(.NB(MAX_BYTES), .AW(RD_AW)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_id  <= '0;
            crc_error <= 1'b0;
        end else if (fend.valid) begin
            frame_id  <= fend.ident;
            crc_error <= (fend.rx_crc != crc_calc);
        end
    end

    // R1: a dominant bit while idle opens a frame
    p_busy_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && bit_valid && !bit_in) |=> busy);

    // R7: the last CRC bit closes the frame
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        fend.valid |=> !busy);

    // R8: results hold while idle
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(frame_id) && $stable(crc_error)));

endmodule

// File: tb/can_frame_parser_tb_top.sv
`timescale 1ns/1ps
module can_frame_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b1;
    logic [3:0]  rd_addr = 4'd0;
    logic [10:0] frame_id;
    logic [7:0]  rd_byte;
    logic        busy;
    logic        crc_error;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [10:0] id;
        logic        cerr;
    } exp_t;

    exp_t exp_q[$];
    logic bits [0:199];
    int   nbits;

    always #2.5 clk = ~clk;

    can_frame_parser dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .rd_addr   (rd_addr),
        .frame_id  (frame_id),
        .rd_byte   (rd_byte),
        .busy      (busy),
        .crc_error (crc_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop the expected frame result when busy falls
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (prev && !busy) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected frame end", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R2 identifier", 32'(frame_id), 32'(e.id));
                    check("R6 crc flag", 32'(crc_error), 32'(e.cerr));
                end
            end
            prev = busy;
        end
    end

    task automatic send_frame(input logic [10:0] id, input logic [3:0] dlc,
                              input logic [63:0] data, input bit bad,
                              input int gap, input bit probe_clear);
        int nb;
        logic [14:0] crc;
        exp_t e;
        nb = (dlc > 4'd8) ? 8 : int'(dlc);
        nbits = 0;
        bits[nbits++] = 1'b0;
        for (int i = 10; i >= 0; i--) bits[nbits++] = id[i];
        for (int i = 0; i < 3; i++) bits[nbits++] = 1'b0;
        for (int i = 3; i >= 0; i--) bits[nbits++] = dlc[i];
        for (int k = 0; k < nb; k++)
            for (int j = 7; j >= 0; j--) bits[nbits++] = data[8*k + j];
        crc = 15'd0;
        for (int i = 0; i < nbits; i++) begin
            logic fb;
            fb = bits[i] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        e.id = id;
        e.cerr = bad;
        if (bad) crc = crc ^ 15'h0001;
        for (int i = 14; i >= 0; i--) bits[nbits++] = crc[i];
        exp_q.push_back(e);

        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i == 1) check("R1 busy after start", 32'(busy), 32'd1);
            if (probe_clear && i == 5) rd_addr = 4'd0;
            if (probe_clear && i == 7) check("R9 store emptied by start", 32'(rd_byte), 32'd0);
            bit_valid = 1'b1;
            bit_in = bits[i];
            for (int j = 0; j < gap; j++) begin
                @(negedge clk);
                bit_valid = 1'b0;
                if (j == 0 && i == nbits - 1)
                    check("R7 busy low after last crc bit", 32'(busy), 32'd0);
            end
        end
        if (gap == 0) begin
            @(negedge clk);
            bit_valid = 1'b0;
            check("R7 busy low after last crc bit", 32'(busy), 32'd0);
        end
        repeat (2) @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            logic [7:0] ex;
            rd_addr = 4'(a);
            @(negedge clk);
            ex = (a < nb) ? data[8*a +: 8] : 8'd0;
            if (a >= nb) check("R5 out of range read", 32'(rd_byte), 32'(ex));
            else         check("R4 payload byte", 32'(rd_byte), 32'(ex));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset busy", 32'(busy), 32'd0);
        check("reset frame_id", 32'(frame_id), 32'd0);
        check("reset crc_error", 32'(crc_error), 32'd0);
        check("reset rd_byte", 32'(rd_byte), 32'd0);

        // R1: recessive bits while idle
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in = 1'b1;
        end
        @(negedge clk);
        bit_valid = 1'b0;
        check("R1 ones keep idle", 32'(busy), 32'd0);

        send_frame(11'h596, 4'd2, 64'h0000_0000_0000_ADAC, 1'b0, 1, 1'b0);
        send_frame(11'h596, 4'd8, 64'hED3D_AFA5_8DA9_ADAC, 1'b0, 0, 1'b1);
        send_frame(11'h7FF, 4'd0, 64'h0, 1'b0, 2, 1'b1);   // R3 zero length
        send_frame(11'h000, 4'd13, 64'h0102_0304_F0E0_D0C0, 1'b0, 0, 1'b0); // R3 clamp
        send_frame(11'h123, 4'd3, 64'h0000_0000_00FF_0080, 1'b1, 1, 1'b0);  // R6 bad crc

        // R8: idle ones and gaps leave the results alone
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_valid = (i % 2) == 0;
            bit_in = 1'b1;
        end
        @(negedge clk);
        bit_valid = 1'b0;
        check("R8 frame_id held", 32'(frame_id), 32'h123);
        check("R8 crc_error held", 32'(crc_error), 32'd1);

        send_frame(11'h2A5, 4'd1, 64'h0000_0000_0000_003C, 1'b0, 0, 1'b1);
        check("R6 crc flag cleared on good frame", 32'(crc_error), 32'd0);
        check("R2 all frames consumed", 32'(exp_q.size()), 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule